// File: doc/BRIEF.md
# Probe-Triggered Phase Capture Unit

The unit keeps a running phase value by adding a signed increment to an integrator on every clock, and presents that running value on a live output. A rising edge on the touch-probe input freezes the running value into a capture register. The register that held the most recent capture passes its value on to a second register, so the unit always holds the newest capture and the one before it.

Captures are one-shot. After a probe edge has been accepted, the probe is disarmed, and it stays disarmed until a rising edge arrives on the re-arm input. A two-step counter decides when the difference between the two captures is published. Left alone, the counter publishes on every second accepted capture. A level input holds the counter at zero, and an edge on the preload input primes the counter so that the next capture publishes. The probe, re-arm and preload inputs may come from outside the clock domain, so each passes through a two-flop synchronizer before its rising edge is detected.

Top module: `probe_phase_latch`

## Requirements
- R1: On every clock edge out of reset, the live phase output becomes its previous value plus the phase increment, in 32-bit two's complement, wrapping modulo 2^32.
- R2: If the probe input is first sampled high at clock edge k while the probe is armed, then at edge k+2 the newest-capture output takes the live phase value held just before that edge.
- R3: After a capture has been accepted, further rising edges on the probe input leave both capture outputs unchanged until a rising edge on the re-arm input has taken effect (re-arm sampled high at edge j arms the probe from edge j+2).
- R4: On each accepted capture, the previous-capture output takes the value the newest-capture output held before that capture.
- R5: The difference output equals newest capture minus previous capture, modulo 2^32, and changes only when a difference is published.
- R6: With no counter control, the first accepted capture after reset leaves the difference unchanged, the second publishes it, and this alternation repeats.
- R7: While the counter-clear input is high, the counter is held at zero, and accepted captures are stored but publish no difference.
- R8: A rising edge on the preload input primes the counter so that the next accepted capture publishes. If the preload edge and a capture take effect on the same clock, the preload wins: the capture is stored, nothing is published, and the capture after it publishes.
- R9: Reset (rst_n low) sets the live phase, both capture outputs and the difference to zero, clears the counter, and leaves the probe armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| phase_inc_i | input | 32 | Signed phase increment added every cycle |
| probe_i | input | 1 | Touch-probe trigger, asynchronous |
| rearm_i | input | 1 | Re-arm request for the probe, asynchronous, edge acting |
| ctr_clr_i | input | 1 | Counter-clear level, synchronous to clk |
| preload_i | input | 1 | Counter preload request, asynchronous, edge acting |
| phase_live_o | output | 32 | Running integrator value |
| cap_last_o | output | 32 | Newest captured phase |
| cap_prev_o | output | 32 | Second-newest captured phase |
| cap_diff_o | output | 32 | Published difference, newest minus previous |

## Verification
A preload edge and an accepted probe edge can act on the same clock. The priority between them decides whether that capture publishes. The bench raises the probe and preload inputs at the same falling edge, so that both pass through identical synchronizers and their rising edges are detected together. The expected result is that the capture is stored while the difference stays unchanged, and that the capture after it publishes. Counter-clear held high during captures is a second overlap, and it is judged the same way, through the capture and difference outputs.

// File: rtl/ppl_pkg.sv
package ppl_pkg;
  // Two-step counter: primed means the next accepted capture publishes.
  typedef enum logic {
    STEP_IDLE   = 1'b0,
    STEP_PRIMED = 1'b1
  } step_e;

  localparam int NUM_ASYNC = 3;
  localparam int IDX_PROBE = 0;
  localparam int IDX_REARM = 1;
  localparam int IDX_PRELD = 2;
endpackage

// File: rtl/ppl_edge_sync.sv
module ppl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ppl_integrator.sv
module ppl_integrator #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inc,
  output logic [W-1:0] acc
);
  logic [W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/ppl_capture.sv
module ppl_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         probe_rise,
  input  logic         rearm_rise,
  input  logic [W-1:0] acc,
  output logic [W-1:0] cap_last,
  output logic [W-1:0] cap_prev,
  output logic         fire
);
  logic [W-1:0] last_q, last_d, prev_q, prev_d;
  logic         armed_q, armed_d;

  assign fire = probe_rise & armed_q;

  always_comb begin
    last_d  = last_q;
    prev_d  = prev_q;
    armed_d = armed_q;
    if (fire) begin
      last_d  = acc;
      prev_d  = last_q;
      armed_d = 1'b0;
    end
    if (rearm_rise) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      prev_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      if (fire) begin
        last_q <= last_d;
        prev_q <= prev_d;
      end
      armed_q <= armed_d;
    end
  end

  assign cap_last = last_q;
  assign cap_prev = prev_q;
endmodule

// File: rtl/ppl_step_gate.sv
module ppl_step_gate
  import ppl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         preload_rise,
  input  logic         fire,
  input  logic [W-1:0] cap_new,
  input  logic [W-1:0] cap_old,
  output logic [W-1:0] diff
);
  step_e        step_q, step_d;
  logic [W-1:0] diff_q, diff_d;
  logic         pub;

  // Priority: clear, then preload, then capture.
  always_comb begin
    step_d = step_q;
    pub    = 1'b0;
    if (clr) begin
      step_d = STEP_IDLE;
    end else if (preload_rise) begin
      step_d = STEP_PRIMED;
    end else if (fire) begin
      if (step_q == STEP_PRIMED) begin
        pub    = 1'b1;
        step_d = STEP_IDLE;
      end else begin
        step_d = STEP_PRIMED;
      end
    end
    diff_d = cap_new - cap_old;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_IDLE;
      diff_q <= '0;
    end else begin
      step_q <= step_d;
      if (pub) diff_q <= diff_d;
    end
  end

  assign diff = diff_q;
endmodule

// File: rtl/probe_phase_latch.sv
module probe_phase_latch
  import ppl_pkg::*;
#(
  parameter int PH_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] phase_inc_i,
  input  logic            probe_i,
  input  logic            rearm_i,
  input  logic            ctr_clr_i,
  input  logic            preload_i,
  output logic [PH_W-1:0] phase_live_o,
  output logic [PH_W-1:0] cap_last_o,
  output logic [PH_W-1:0] cap_prev_o,
  output logic [PH_W-1:0] cap_diff_o
);
  logic [NUM_ASYNC-1:0] async_in, rise_vec;
  logic [PH_W-1:0]      acc;
  logic                 cap_fire;

  always_comb begin
    async_in            = '0;
    async_in[IDX_PROBE] = probe_i;
    async_in[IDX_REARM] = rearm_i;
    async_in[IDX_PRELD] = preload_i;
  end

  for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
    ppl_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (async_in[g]),
      .rise (rise_vec[g])
    );
  end

  ppl_integrator #(.W(PH_W)) u_integ (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (phase_inc_i),
    .acc  (acc)
  );

  ppl_capture #(.W(PH_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_rise(rise_vec[IDX_PROBE]),
    .rearm_rise(rise_vec[IDX_REARM]),
    .acc       (acc),
    .cap_last  (cap_last_o),
    .cap_prev  (cap_prev_o),
    .fire      (cap_fire)
  );

  ppl_step_gate #(.W(PH_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (ctr_clr_i),
    .preload_rise(rise_vec[IDX_PRELD]),
    .fire        (cap_fire),
    .cap_new     (acc),
    .cap_old     (cap_last_o),
    .diff        (cap_diff_o)
  );

  assign phase_live_o = acc;
endmodule

// File: rtl/ppl_checker.sv
module ppl_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] phase_inc_i,
  input logic         ctr_clr_i,
  input logic [W-1:0] phase_live_o,
  input logic [W-1:0] cap_last_o,
  input logic [W-1:0] cap_prev_o,
  input logic [W-1:0] cap_diff_o,
  input logic         cap_fire
);
  // R1
  integ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_live_o == $past(phase_live_o) + $past(phase_inc_i));

  // R2
  cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_last_o == $past(phase_live_o));

  // R3
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(cap_last_o) && $stable(cap_prev_o));

  // R4
  cap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_prev_o == $past(cap_last_o));

  // R5
  diff_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_diff_o) |-> cap_diff_o == cap_last_o - cap_prev_o);

  // R7
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clr_i |=> $stable(cap_diff_o));
endmodule

bind probe_phase_latch ppl_checker #(.W(PH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase_inc_i (phase_inc_i),
  .ctr_clr_i   (ctr_clr_i),
  .phase_live_o(phase_live_o),
  .cap_last_o  (cap_last_o),
  .cap_prev_o  (cap_prev_o),
  .cap_diff_o  (cap_diff_o),
  .cap_fire    (cap_fire)
);

// File: tb/probe_phase_latch_test.sv
module probe_phase_latch_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] phase_inc;
  logic         probe, rearm, ctr_clr, preload;
  logic [W-1:0] phase_live, cap_last, cap_prev, cap_diff;

  always #5 clk = ~clk;

  probe_phase_latch uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_inc_i (phase_inc),
    .probe_i     (probe),
    .rearm_i     (rearm),
    .ctr_clr_i   (ctr_clr),
    .preload_i   (preload),
    .phase_live_o(phase_live),
    .cap_last_o  (cap_last),
    .cap_prev_o  (cap_prev),
    .cap_diff_o  (cap_diff)
  );

  typedef struct {
    int unsigned  due;
    logic [W-1:0] last;
    logic [W-1:0] prev;
    logic [W-1:0] diff;
    string        req;
  } item_t;

  item_t        sb_q[$];
  int           n_cmp = 0;
  int           n_bad = 0;
  int unsigned  cyc = 0;
  bit           done = 0;

  // Requirement-level model state
  logic [W-1:0] m_acc;
  logic [W-1:0] m_last, m_prev, m_diff;
  bit           m_armed;
  bit           m_primed;

  always @(posedge clk) cyc <= cyc + 1;

  // R1 model: running sum of the increments since reset
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_acc <= '0;
    else        m_acc <= m_acc + phase_inc;
  end

  task automatic cmp(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops items when their capture edge has passed
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      cmp(it.req, "cap_last", cap_last, it.last);
      cmp(it.req, "cap_prev", cap_prev, it.prev);
      cmp(it.req, "cap_diff", cap_diff, it.diff);
    end
  end

  task automatic model_reset();
    m_last = '0; m_prev = '0; m_diff = '0;
    m_armed = 1; m_primed = 0;
  endtask

  // Driver: probe pulse, optionally together with a preload pulse
  task automatic probe_shot(input string req, input bit with_preload);
    item_t it;
    @(negedge clk);
    probe = 1'b1;
    if (with_preload) preload = 1'b1;
    @(negedge clk);
    preload = 1'b0;
    @(negedge clk);
    // m_acc now equals the value the design samples at the capture edge (R2)
    if (m_armed) begin
      m_prev  = m_last;
      m_last  = m_acc;
      m_armed = 0;
      if (ctr_clr) m_primed = 0;                 // R7
      else if (with_preload) m_primed = 1;       // R8
      else if (m_primed) begin                   // R5 R6
        m_diff   = m_last - m_prev;
        m_primed = 0;
      end else m_primed = 1;
    end else if (with_preload && !ctr_clr) begin
      m_primed = 1;
    end
    it.due  = cyc + 1;
    it.last = m_last;
    it.prev = m_prev;
    it.diff = m_diff;
    it.req  = req;
    sb_q.push_back(it);
    @(negedge clk);
    probe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rearm_pulse();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    repeat (4) @(negedge clk);
    m_armed = 1;
  endtask

  task automatic preload_pulse();
    @(negedge clk);
    preload = 1'b1;
    @(negedge clk);
    preload = 1'b0;
    repeat (4) @(negedge clk);
    if (!ctr_clr) m_primed = 1;
  endtask

  task automatic check_live(input string req);
    @(negedge clk);
    cmp(req, "phase_live", phase_live, m_acc);
  endtask

  task automatic check_zero(input string req);
    cmp(req, "phase_live", phase_live, '0);
    cmp(req, "cap_last", cap_last, '0);
    cmp(req, "cap_prev", cap_prev, '0);
    cmp(req, "cap_diff", cap_diff, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phase_inc = '0; probe = 0; rearm = 0; ctr_clr = 0; preload = 0;
    model_reset();
    repeat (3) @(negedge clk);
    check_zero("R9");                            // R9 reset state
    rst_n = 1'b1;
    phase_inc = 32'd5;
    repeat (4) @(negedge clk);
    check_live("R1");                            // R1 accumulation

    probe_shot("R2", 0);                         // R2 first capture, no publish (R6)
    probe_shot("R3", 0);                         // R3 ignored while disarmed
    phase_inc = 32'hFFFF_FFFD;                   // negative increment
    check_live("R1");
    rearm_pulse();
    probe_shot("R4", 0);                         // R4 shift, R6 publish
    rearm_pulse();
    probe_shot("R6", 0);                         // R6 no publish
    rearm_pulse();
    probe_shot("R6", 0);                         // R6 publish
    rearm_pulse();
    preload_pulse();
    probe_shot("R8", 0);                         // R8 preload then publish

    ctr_clr = 1'b1;                              // R7 clear held high
    rearm_pulse();
    probe_shot("R7", 0);
    rearm_pulse();
    probe_shot("R7", 0);
    @(negedge clk);
    ctr_clr = 1'b0;
    rearm_pulse();
    probe_shot("R7", 0);                         // R7 counter restarted from zero

    rearm_pulse();
    probe_shot("R6", 0);                         // publish, counter back to idle
    rearm_pulse();
    probe_shot("R8", 1);                         // R8 collision: stored, not published
    rearm_pulse();
    probe_shot("R8", 0);                         // R8 publishes after collision

    phase_inc = 32'h7FFF_FFF0;                   // R1 R5 wrap-around
    rearm_pulse();
    probe_shot("R5", 0);
    repeat (3) @(negedge clk);
    rearm_pulse();
    probe_shot("R5", 0);
    check_live("R1");

    @(negedge clk);
    rst_n = 1'b0;                                // R9 mid-run reset
    model_reset();
    @(negedge clk);
    check_zero("R9");
    rst_n = 1'b1;
    phase_inc = 32'd7;
    repeat (2) @(negedge clk);
    probe_shot("R9", 0);                         // R9 armed after reset, no publish
    check_live("R1");

    repeat (4) @(negedge clk);
    n_cmp++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending items actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule